// File: doc/BRIEF.md
# Realignable Clock Divider

This block divides a fast, free-running system clock by a power of two with a down-counter. The top bit of the counter drives the divided clock. A receiver elsewhere on the chip raises a strobe when it recognises a framing pattern in its incoming data. On the rising edge of that strobe, the block loads the counter with a programmable value. This snaps the phase of the divided clock to the data stream without stopping the count.

Edge detection and reload both run in the system clock domain, so the strobe never clocks or clears a flip-flop directly. The load replaces one decrement, so the divided clock keeps running through a realignment. A one-cycle pulse tells downstream logic that the phase has just been reset.

The width is set by `CNT_W`. The default of 5 gives a divide-by-32, for example 65.536 MHz down to 2.048 MHz.

Top module: `rsdiv_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter and the strobe history are cleared. After that edge, `div_clk_o` and `realign_o` are both 0.
- R2: At each rising edge that does not reload, the counter decreases by one, wrapping from 0 to 2^CNT_W-1. `div_clk_o` equals the counter's most significant bit. Left alone, it has a period of 2^CNT_W cycles and a 50% duty cycle, and it is high for the 2^(CNT_W-1) cycles that follow reset release.
- R3: A rising edge of `strobe_i` means `strobe_i` is 1 at a clock edge and was 0 at the previous edge. At such an edge the counter is loaded with `reload_i` instead of decrementing, so `div_clk_o` shows bit CNT_W-1 of `reload_i` from that edge on.
- R4: `realign_o` is 1 for exactly the one cycle that follows each reload edge, and is 0 otherwise.
- R5: A strobe held high for many cycles causes one reload only, at its first high edge.
- R6: The falling edge of `strobe_i` and its steady low level have no effect: counting continues and `realign_o` stays 0.
- R7: A reload whose value equals what the decrement would have produced leaves the `div_clk_o` waveform unchanged, but still raises `realign_o`.
- R8: `reload_i` is sampled only at a reload edge. Changing it at any other time has no effect on `div_clk_o`.
- R9: Because reset clears the strobe history, a strobe that is already high at the first edge after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | Pattern-detected strobe, synchronous to `clk` |
| reload_i | input | CNT_W | Counter value loaded on a realignment; sets the new phase |
| div_clk_o | output | 1 | Divided clock (counter MSB) |
| realign_o | output | 1 | One-cycle pulse after each realignment |

## Verification
A wrong counter value shows up on `div_clk_o` only when it changes the MSB. The error therefore becomes visible at the next half-period boundary, which can be up to 2^(CNT_W-1) cycles later. It then stays visible as a shifted edge until the next reload hides it. A broken edge detector shows up one cycle after the strobe, either as a missing or doubled `realign_o` pulse or as a second phase jump while the strobe is held high. Because of this, the bench compares both outputs against a reference model on every cycle rather than only at edges.

// File: rtl/rsdiv_pkg.sv
// Package: shared defaults for the realignable divider.
// Assumes: consumers take widths from here unless overridden.
package rsdiv_pkg;
    // Default counter width: divide by 2**5 = 32
    localparam int unsigned DEF_CNT_W = 5;
endpackage

// File: rtl/rsdiv_edge.sv
// Module: rsdiv_edge
// Registers the strobe and flags a rising edge: high now, low at the
// previous clock edge. Assumes the strobe is already synchronous to clk.
// Reset clears the history, so a strobe high at release counts as a rise.
module rsdiv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic prev_q;

    // Holds the strobe level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_i;
    end

    // Rising edge: current high, previous low
    always_comb rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/rsdiv_counter.sv
// Module: rsdiv_counter
// Down-counter with a synchronous load; the MSB is the divided clock.
// Assumes load_i is a single-cycle request in the clk domain.
module rsdiv_counter #(
    parameter int unsigned CNT_W = rsdiv_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             msb_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    // Load replaces the decrement so no output period is lost
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= reload_i;
        else             count_q <= count_q - ONE;
    end

    // Expose the count and its top bit
    always_comb begin
        count_o = count_q;
        msb_o   = count_q[CNT_W-1];
    end
endmodule

// File: rtl/rsdiv_top.sv
// Module: rsdiv_top
// Divides clk by 2**CNT_W and realigns the phase on each strobe rise.
// Assumes strobe_i and reload_i are synchronous to clk.
module rsdiv_top #(
    parameter int unsigned CNT_W = rsdiv_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             div_clk_o,
    output logic             realign_o
);
    logic             rise;
    logic [CNT_W-1:0] count_q;
    logic             realign_q;

    rsdiv_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .rise_o   (rise)
    );

    rsdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (rise),
        .reload_i (reload_i),
        .count_o  (count_q),
        .msb_o    (div_clk_o)
    );

    // Flags the cycle that follows each reload
    always_ff @(posedge clk) begin
        if (!rst_n) realign_q <= 1'b0;
        else        realign_q <= rise;
    end

    always_comb realign_o = realign_q;
endmodule

// File: rtl/rsdiv_chk.sv
// Module: rsdiv_chk
// Property checker for rsdiv_top, attached with bind below.
// Keeps its own copy of the strobe history.
module rsdiv_chk #(
    parameter int unsigned CNT_W = rsdiv_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_i,
    input logic [CNT_W-1:0] reload_i,
    input logic [CNT_W-1:0] count,
    input logic             div_clk_o,
    input logic             realign_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic seen_q;

    // Independent record of the strobe level at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= strobe_i;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!div_clk_o && !realign_o));

    // R3
    reload_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !seen_q) |=> (count == $past(reload_i) && realign_o));

    // R2
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && !seen_q) |=> (count == ($past(count) - ONE)));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |=> !realign_o);

    // R5
    held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && seen_q) |=> !realign_o);
endmodule

bind rsdiv_top rsdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_i),
    .reload_i  (reload_i),
    .count     (count_q),
    .div_clk_o (div_clk_o),
    .realign_o (realign_o)
);

// File: tb/tb_rsdiv_top.sv
module tb_rsdiv_top;
    localparam int unsigned W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobe = 1'b0;
    logic [W-1:0] reload = '0;
    logic         div_clk;
    logic         realign;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // reference model state
    logic [W-1:0] m_cnt = '0;
    logic         m_prev = 1'b0;
    logic         m_pulse = 1'b0;

    always #5 clk = ~clk;

    rsdiv_top #(.CNT_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe),
        .reload_i  (reload),
        .div_clk_o (div_clk),
        .realign_o (realign)
    );

    function automatic logic exp_msb(input logic [W-1:0] c);
        return c[W-1];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a negedge: drive inputs, advance the model one edge, compare.
    task automatic step(input string tag, input logic r, input logic s, input logic [W-1:0] v);
        logic rise;
        rst_n = r; strobe = s; reload = v;
        @(posedge clk);
        if (!r) begin
            m_cnt = '0; m_prev = 1'b0; m_pulse = 1'b0;
        end else begin
            rise    = s && !m_prev;
            m_pulse = rise;
            m_cnt   = rise ? v : m_cnt - 1'b1;
            m_prev  = s;
        end
        @(negedge clk);
        check(tag, div_clk, exp_msb(m_cnt), "div_clk_o");
        check(tag, realign, m_pulse, "realign_o");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] nxt;
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) step("R1", 1'b0, 1'b0, 5'h15);
        // R2: free running, several periods
        for (int i = 0; i < 80; i++) step("R2", 1'b1, 1'b0, '0);
        // R3 / R4: single-cycle strobe
        step("R3", 1'b1, 1'b1, 5'h0A);
        for (int i = 0; i < 20; i++) step("R4", 1'b1, 1'b0, 5'h1F);
        step("R3", 1'b1, 1'b1, 5'h1C);
        for (int i = 0; i < 5; i++) step("R4", 1'b1, 1'b0, '0);
        // R5: strobe held high
        for (int i = 0; i < 40; i++) step("R5", 1'b1, 1'b1, W'(i));
        // R6: falling edge and low level
        for (int i = 0; i < 40; i++) step("R6", 1'b1, 1'b0, 5'h07);
        // R8: reload changes without strobe
        for (int i = 0; i < 40; i++) step("R8", 1'b1, 1'b0, W'($urandom));
        // R7: reload equal to the next decremented value
        for (int k = 0; k < 3; k++) begin
            nxt = m_cnt - 1'b1;
            step("R7", 1'b1, 1'b1, nxt);
            for (int i = 0; i < 12; i++) step("R7", 1'b1, 1'b0, '0);
        end
        // R9: strobe high through reset release
        for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b1, 5'h03);
        step("R9", 1'b1, 1'b1, 5'h03);
        for (int i = 0; i < 6; i++) step("R9", 1'b1, 1'b1, 5'h11);
        // random mix, including occasional reset
        for (int i = 0; i < 4000; i++)
            step("R3", ($urandom % 200) != 0, ($urandom % 5) == 0, W'($urandom));
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule